// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

A bank of general-purpose pins behind a simple 32-bit register bus. Software programs each pin's direction, its output level and its pad pull controls. Output data writes pass through a per-bit write-enable mask. Because of that mask, one pin can be changed without a read-modify-write of the whole data word. Reading the data word returns the driven level for output pins and the synchronised pad level for input pins.

Every pin also has its own interrupt detector. Each detector senses either a level or an edge. In edge mode it can take one edge of a chosen polarity or both edges. Detected events collect in a raw status word, whatever the enable bits hold. The enabled subset forms a masked status word, and any bit set there raises the single bank interrupt line. Software clears edge events by writing ones to a clear register. The bank width is a parameter, so the same block serves a 16-pin bank and a 32-pin bank.

Top module: `gpio_bank`

## Requirements
- R1: Direction register (byte offset 0x08): bit value 1 makes that pin an output (`pin_oe_o` bit high); 0 makes it an input. Reset value 0.
- R2: A write to the data register (0x00) updates output bit i only where bit i of the data-enable register (0x04) is 1; every other pin keeps its previous output value. Both registers reset to 0.
- R3: Reading 0x00 returns, per pin, the driven output bit where the direction bit is 1, and the pad level after the two-flop synchroniser where it is 0.
- R4: Pull-up register (0x0C) is active-low, so bit 1 turns the pull-up off (`pu_en_o` bit 0). Pull-down register (0x10) is active-high, so bit 1 turns the pull-down on (`pd_en_o` bit 1). Both reset to 0, so all pull-ups are on after reset.
- R5: With sense bit (0x14) 0 and both-edges bit (0x18) 0, polarity bit (0x1C) 1 flags a rising edge and 0 flags a falling edge; the other edge sets nothing.
- R6: With sense bit 0 and both-edges bit 1, both edges set the raw status bit, and the polarity bit has no effect.
- R7: With sense bit 1, the raw status bit follows the active level every cycle (high when polarity is 1, low when it is 0). A clear written while the level is active leaves the bit set.
- R8: Raw status (0x24, read-only) holds events whatever the interrupt-enable bits (0x20) hold. Masked status (0x28) is raw AND enable. `irq_o` is high exactly when some masked bit is set.
- R9: Writing 1 to bit i of the clear register (0x2C, write-only, reads 0) clears edge-sensed raw bit i; bits written 0 leave their status unchanged.
- R10: When an edge on pin i is detected in the same cycle that a clear of bit i is written, the raw bit ends up set.
- R11: Register bits at or above NPINS read as 0, and writes to them have no effect.
- R12: A pad change is recorded in raw status on the third rising clock edge after it appears at `pin_i`, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write is taken at the rising clock edge |
| bus_addr | input | 8 | Byte address of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_i | input | NPINS | Pad input levels (asynchronous) |
| pin_o | output | NPINS | Output data to the pads |
| pin_oe_o | output | NPINS | Pad output enable, 1 = drive |
| pu_en_o | output | NPINS | Pull-up enable to the pads, 1 = on |
| pd_en_o | output | NPINS | Pull-down enable to the pads, 1 = on |
| irq_o | output | 1 | Bank interrupt, any masked status bit set |

## Verification
The bench builds the block with NPINS = 16, the narrower bank width. With this width, writing all ones to the upper half of the bus shows that the upper lanes stay at zero in every register and at every pad output. The low pins go through rising, falling and both-edge sensing and through high-level sensing. The bench counts clock edges to pin down the three-cycle detection latency. It also lines up a pad edge with a clear write on the same clock edge, to show that the set takes priority.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pu_en_o,
  output logic [NPINS-1:0] pd_en_o,
  output logic             irq_o
);
  localparam int W = NPINS;
  localparam logic [7:0] A_DATA  = 8'h00;
  localparam logic [7:0] A_DEN   = 8'h04;
  localparam logic [7:0] A_DIR   = 8'h08;
  localparam logic [7:0] A_PUOFF = 8'h0C;
  localparam logic [7:0] A_PDON  = 8'h10;
  localparam logic [7:0] A_SENSE = 8'h14;
  localparam logic [7:0] A_BOTH  = 8'h18;
  localparam logic [7:0] A_POL   = 8'h1C;
  localparam logic [7:0] A_IEN   = 8'h20;
  localparam logic [7:0] A_RAW   = 8'h24;
  localparam logic [7:0] A_MSK   = 8'h28;
  localparam logic [7:0] A_CLR   = 8'h2C;

  logic [W-1:0] out_q, den_q, dir_q, puoff_q, pdon_q;
  logic [W-1:0] sense_q, both_q, pol_q, ien_q, raw_q, raw_d;
  logic [W-1:0] s1_q, s2_q, s3_q, edge_hit, masked;
  logic [W-1:0] wd;
  logic         we_clr;

  assign wd     = bus_wdata[W-1:0];
  assign we_clr = bus_wr && (bus_addr == A_CLR);
  assign masked = raw_q & ien_q;

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign pu_en_o  = ~puoff_q;
  assign pd_en_o  = pdon_q;
  assign irq_o    = |masked;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, act, hit;
    assign rise        = s2_q[i] & ~s3_q[i];
    assign fall        = ~s2_q[i] & s3_q[i];
    assign act         = pol_q[i] ? s2_q[i] : ~s2_q[i];
    assign hit         = both_q[i] ? (rise | fall) : (pol_q[i] ? rise : fall);
    assign edge_hit[i] = ~sense_q[i] & hit;
    assign raw_d[i]    = sense_q[i] ? act
                                    : (hit | (raw_q[i] & ~(we_clr & wd[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; den_q <= '0; dir_q <= '0; puoff_q <= '0; pdon_q <= '0;
      sense_q <= '0; both_q <= '0; pol_q <= '0; ien_q <= '0; raw_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      raw_q <= raw_d;
      if (bus_wr) begin
        case (bus_addr)
          A_DATA:  out_q   <= (out_q & ~den_q) | (wd & den_q);
          A_DEN:   den_q   <= wd;
          A_DIR:   dir_q   <= wd;
          A_PUOFF: puoff_q <= wd;
          A_PDON:  pdon_q  <= wd;
          A_SENSE: sense_q <= wd;
          A_BOTH:  both_q  <= wd;
          A_POL:   pol_q   <= wd;
          A_IEN:   ien_q   <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:  bus_rdata[W-1:0] = (dir_q & out_q) | (~dir_q & s2_q);
      A_DEN:   bus_rdata[W-1:0] = den_q;
      A_DIR:   bus_rdata[W-1:0] = dir_q;
      A_PUOFF: bus_rdata[W-1:0] = puoff_q;
      A_PDON:  bus_rdata[W-1:0] = pdon_q;
      A_SENSE: bus_rdata[W-1:0] = sense_q;
      A_BOTH:  bus_rdata[W-1:0] = both_q;
      A_POL:   bus_rdata[W-1:0] = pol_q;
      A_IEN:   bus_rdata[W-1:0] = ien_q;
      A_RAW:   bus_rdata[W-1:0] = raw_q;
      A_MSK:   bus_rdata[W-1:0] = masked;
      default: ;
    endcase
  end

  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> pin_oe_o == $past(wd));

  p_data_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=>
      pin_o == (($past(pin_o) & ~$past(den_q)) | ($past(wd) & $past(den_q))));

  p_clear_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> (raw_q & $past(wd & ~sense_q & ~edge_hit)) == '0);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> (raw_q & $past(edge_hit)) == $past(edge_hit));

  p_ien_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IEN && wd == '0) |=> !irq_o);
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o, pin_oe_o, pu_en_o, pd_en_o;
  logic irq_o;
  int total = 0;
  int bad = 0;
  logic [31:0] v;

  gpio_bank #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .pu_en_o(pu_en_o),
    .pd_en_o(pd_en_o), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(8'h08, v); chk("R1 reset dir", v, 0);
    chk("R1 reset oe", 32'(pin_oe_o), 0);
    chk("R4 reset pull-up", 32'(pu_en_o), 32'h0000_FFFF);
    chk("R4 reset pull-down", 32'(pd_en_o), 0);
    rd(8'h24, v); chk("R8 reset raw", v, 0);
    chk("R8 reset irq", 32'(irq_o), 0);
  endtask

  task automatic t_dir_data;
    wr(8'h08, 32'h0000_00F0);
    chk("R1 oe", 32'(pin_oe_o), 32'h00F0);
    wr(8'h04, 32'h0000_00FF);
    wr(8'h00, 32'h0000_ABCD);
    chk("R2 low byte", 32'(pin_o), 32'h00CD);
    wr(8'h04, 32'h0000_FF00);
    wr(8'h00, 32'h0000_1234);
    chk("R2 high byte", 32'(pin_o), 32'h12CD);
  endtask

  task automatic t_readback;
    @(negedge clk); pin_i = 16'h5A0F;
    settle(3);
    rd(8'h00, v); chk("R3 readback", v, 32'h0000_5ACF);
    @(negedge clk); pin_i = '0;
    settle(4);
    wr(8'h2C, 32'h0000_FFFF);
    rd(8'h24, v); chk("R9 clear all", v, 0);
  endtask

  task automatic t_pull;
    wr(8'h0C, 32'h0000_000F);
    chk("R4 pull-up off", 32'(pu_en_o), 32'hFFF0);
    wr(8'h10, 32'h0000_0003);
    chk("R4 pull-down on", 32'(pd_en_o), 32'h0003);
  endtask

  task automatic t_edge;
    wr(8'h1C, 32'h0000_0001);
    @(negedge clk); pin_i = 16'h0003;
    @(negedge clk); @(negedge clk);
    rd(8'h24, v); chk("R12 not before third edge", v, 0);
    @(negedge clk);
    rd(8'h24, v); chk("R5 rising only pin0 / R12", v, 32'h1);
    @(negedge clk); pin_i = '0;
    settle(4);
    rd(8'h24, v); chk("R5 falling pin1", v, 32'h3);
    rd(8'h28, v); chk("R8 masked with enables off", v, 0);
    chk("R8 irq off", 32'(irq_o), 0);
    wr(8'h20, 32'h0000_0002);
    rd(8'h28, v); chk("R8 masked", v, 32'h2);
    chk("R8 irq on", 32'(irq_o), 1);
    wr(8'h2C, 32'h0000_0001);
    rd(8'h24, v); chk("R9 clear one bit", v, 32'h2);
    wr(8'h2C, 32'h0000_0002);
    rd(8'h24, v); chk("R9 clear second", v, 0);
    chk("R8 irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_both;
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'h0000_0004);
    @(negedge clk); pin_i = 16'h0004;
    settle(4);
    rd(8'h24, v); chk("R6 rising with polarity 0", v, 32'h4);
    wr(8'h2C, 32'h0000_0004);
    @(negedge clk); pin_i = '0;
    settle(4);
    rd(8'h24, v); chk("R6 falling", v, 32'h4);
    wr(8'h2C, 32'h0000_0004);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_level;
    wr(8'h1C, 32'h0000_0008);
    wr(8'h14, 32'h0000_0008);
    rd(8'h24, v); chk("R7 level inactive", v, 0);
    @(negedge clk); pin_i = 16'h0008;
    settle(4);
    rd(8'h24, v); chk("R7 level active", v, 32'h8);
    wr(8'h20, 32'h0000_0008);
    chk("R8 irq from level", 32'(irq_o), 1);
    wr(8'h2C, 32'h0000_0008);
    rd(8'h24, v); chk("R7 clear while active", v, 32'h8);
    @(negedge clk); pin_i = '0;
    settle(4);
    rd(8'h24, v); chk("R7 follows level down", v, 0);
    chk("R8 irq released", 32'(irq_o), 0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_set_wins;
    wr(8'h1C, 32'h0000_0020);
    wr(8'h2C, 32'h0000_FFFF);
    @(negedge clk); pin_i = 16'h0020;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h24, v); chk("R10 set beats clear", v, 32'h20);
    wr(8'h2C, 32'h0000_0020);
    rd(8'h24, v); chk("R9 later clear", v, 0);
  endtask

  task automatic t_upper;
    wr(8'h08, 32'hFFFF_0000);
    rd(8'h08, v); chk("R11 upper dir", v, 0);
    chk("R11 oe", 32'(pin_oe_o), 0);
    wr(8'h20, 32'hFFFF_0000);
    rd(8'h20, v); chk("R11 upper enable", v, 0);
    rd(8'h2C, v); chk("R9 clear reads zero", v, 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset;
    t_dir_data;
    t_readback;
    t_pull;
    t_edge;
    t_both;
    t_level;
    t_set_wins;
    t_upper;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule